// File: doc/BRIEF.md
# Half-Bridge Driver Serial Control Interface

This block is the serial command port of a three-channel half-bridge output driver. An external controller pulls chip select low and clocks a 16-bit frame into the port. At the same time the port shifts out a 16-bit status word. The received word is held in a shadow shift register. It reaches the switch enables and the overcurrent-shutdown enable only when chip select is released, and only when the frame had exactly sixteen falling clock edges.

The power stage reports faults as single-cycle strobes. The port keeps each fault in a sticky flag until a committed frame with its status-reset bit set clears it. All serial pins are oversampled with the block clock through a parameterised synchronizer. Every serial event therefore becomes a one-cycle pulse in the clock domain, and every result has a fixed latency.

Top module: `hb_drv_spi`

## Requirements
- R1: After reset, every low-side and high-side enable is 0, the overcurrent-shutdown enable is 0, all fault flags are clear and `sdo_oe` is 0.
- R2: `sdo_oe` goes to 1 after chip select falls and returns to 0 after chip select rises. While it is 0, `sdo` is 0.
- R3: `sdi` is sampled on the falling edges of `sck`, least significant bit first. In the committed word, bit 1+2k drives `low_en[k]`, bit 2+2k drives `high_en[k]` (k = 0..2), and bit 13 drives `ocs_en`.
- R4: The control outputs change only on a commit. A commit takes effect on the third rising `clk` edge after `cs_n` rises, with the default of two synchronizer stages.
- R5: A frame with any number of `sck` falling edges other than 16 is dropped when chip select rises, and every control output keeps its value.
- R6: Input bits 7 to 12, 14 and 15 have no effect on any output.
- R7: The status word is sent least significant bit first. Bit 0 is on `sdo` from the fall of chip select. Bit k (k ≥ 1) appears after the (k+1)-th rising `sck` edge and holds until the next rising edge.
- R8: Status word layout: bit 0 = `temp_warn`, bits 1 to 6 = the current switch enables in the input-word order, bits 7 to 12 = 0, bit 13 = short-circuit flag, bit 14 = open-load flag, bit 15 = supply-fault flag.
- R9: The status word is captured at the fall of chip select. A fault that arrives during a frame first appears in the next frame.
- R10: A fault strobe sets its flag, and the flag stays set through any number of frames that do not clear it.
- R11: A committed frame with bit 0 = 1 clears the three fault flags. `temp_warn` in status bit 0 is not affected.
- R12: A fault strobe in the same cycle as the clear wins, so that flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| temp_warn | input | 1 | Live temperature prewarning level |
| ev_short | input | 1 | Short-circuit event strobe |
| ev_open | input | 1 | Open-load event strobe |
| ev_supply | input | 1 | Supply-fault event strobe |
| low_en | output | 3 | Low-side switch enables |
| high_en | output | 3 | High-side switch enables |
| ocs_en | output | 1 | Overcurrent-shutdown enable |
| sdo | output | 1 | Serial data out, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |

## Verification
A pin change reaches the edge-detect pulse after two synchronizer stages plus one edge register. The action it triggers lands one edge later, so `sdo`, `sdo_oe` and the control outputs move three clock edges after the pin. Fault flags move one edge after a strobe. The bench runs the serial clock with half-periods of eight block clocks and samples `sdo` just before each falling `sck` edge. It reads the control outputs eight clocks after chip select rises, which is well past the three-edge latency. The commit-latency and clear-priority tests count negative clock edges after the chip-select rise: outputs are still old after the second edge and new after the third, and a strobe is placed exactly in the cycle that the third edge samples.

// File: rtl/hb_spi_pkg.sv
package hb_spi_pkg;
   // control word positions
   localparam int CTL_CLR_POS  = 0;
   localparam int CTL_SW_BASE  = 1;
   localparam int CTL_OCS_POS  = 13;
   // status word positions
   localparam int STS_TEMP_POS = 0;
   localparam int STS_FLT_BASE = 13;
   localparam int MIN_FRAME_W  = 16;

   typedef enum logic [1:0] {
      FLT_SHORT  = 2'd0,
      FLT_OPEN   = 2'd1,
      FLT_SUPPLY = 2'd2
   } flt_idx_e;

   localparam int NUM_FLT = 3;
endpackage

// File: rtl/hb_spi_sync.sv
module hb_spi_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic sync_o
);
   logic [STAGES-1:0] chain_q;

   initial begin
      assert (STAGES >= 1) else $error("hb_spi_sync: STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= RST_VAL;
            else        chain_q <= pin_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], pin_i};
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/hb_spi_edge.sv
module hb_spi_edge #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic level;
   logic prev_q;

   hb_spi_sync #(.STAGES(STAGES), .RST_VAL(RST_VAL)) i_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_i),
      .sync_o (level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level;
   end

   assign rise_o = level & ~prev_q;
   assign fall_o = ~level & prev_q;
endmodule

// File: rtl/hb_spi_frame.sv
module hb_spi_frame #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_fall_i,
   input  logic             cs_rise_i,
   input  logic             sck_rise_i,
   input  logic             sck_fall_i,
   input  logic             sdi_i,
   input  logic [WIDTH-1:0] status_i,
   output logic             active_o,
   output logic             sdo_o,
   output logic [WIDTH-1:0] word_o,
   output logic             frame_ok_o
);
   localparam int              CNT_W    = $clog2(WIDTH + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WIDTH);

   logic             active_q;
   logic [WIDTH-1:0] rx_q;
   logic [WIDTH-1:0] tx_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         rx_q     <= '0;
         tx_q     <= '0;
         cnt_q    <= '0;
      end else if (cs_fall_i) begin
         active_q <= 1'b1;
         tx_q     <= status_i;
         cnt_q    <= '0;
      end else if (cs_rise_i) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (sck_fall_i) begin
            rx_q <= {sdi_i, rx_q[WIDTH-1:1]};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         end
         // first rising edge opens bit 0, later ones advance
         if (sck_rise_i && (cnt_q != '0)) begin
            tx_q <= {1'b0, tx_q[WIDTH-1:1]};
         end
      end
   end

   assign active_o   = active_q;
   assign sdo_o      = active_q & tx_q[0];
   assign word_o     = rx_q;
   assign frame_ok_o = (cnt_q == CNT_FULL);

   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !sck_rise_i && !cs_fall_i && !cs_rise_i) |=> $stable(sdo_o)); // R7
   AST_CNT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !sck_fall_i && !cs_fall_i) |=> $stable(cnt_q)); // R5
endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   logic [N-1:0] flag_q;

   generate
      for (genvar k = 0; k < N; k++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          flag_q[k] <= 1'b0;
            else if (set_i[k])   flag_q[k] <= 1'b1;
            else if (clr_i)      flag_q[k] <= 1'b0;
         end

         AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_q[k]); // R12
         AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !set_i[k]) |=> !flag_q[k]); // R11
         AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !clr_i) |=> flag_q[k]); // R10
      end
   endgenerate

   assign flag_o = flag_q;
endmodule

// File: rtl/hb_drv_spi.sv
module hb_drv_spi #(
   parameter int FRAME_W     = 16,
   parameter int NUM_CH      = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              sdi,
   input  logic              temp_warn,
   input  logic              ev_short,
   input  logic              ev_open,
   input  logic              ev_supply,
   output logic [NUM_CH-1:0] low_en,
   output logic [NUM_CH-1:0] high_en,
   output logic              ocs_en,
   output logic              sdo,
   output logic              sdo_oe
);
   import hb_spi_pkg::*;

   function automatic logic [FRAME_W-1:0] used_mask();
      logic [FRAME_W-1:0] m;
      m = '0;
      m[CTL_CLR_POS] = 1'b1;
      m[CTL_OCS_POS] = 1'b1;
      for (int k = 0; k < 2*NUM_CH; k++) m[CTL_SW_BASE+k] = 1'b1;
      return m;
   endfunction

   localparam logic [FRAME_W-1:0] USED_MASK = used_mask();

   initial begin
      assert (FRAME_W >= MIN_FRAME_W)
         else $error("hb_drv_spi: FRAME_W below the 16-bit frame");
      assert (NUM_CH >= 1 && (CTL_SW_BASE + 2*NUM_CH) <= CTL_OCS_POS)
         else $error("hb_drv_spi: NUM_CH collides with the OCS bit");
      assert (SYNC_STAGES >= 1)
         else $error("hb_drv_spi: SYNC_STAGES must be at least 1");
   end

   logic cs_rise, cs_fall, sck_rise, sck_fall, sdi_s;
   logic [FRAME_W-1:0] status_w, rx_word;
   logic frame_ok, active;
   logic commit, clr_flags;
   logic [NUM_FLT-1:0] flt_set, flt_q;
   logic [NUM_CH-1:0] low_q, high_q;
   logic ocs_q;
   logic unused_bits;

   hb_spi_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_cs_edge (
      .clk (clk), .rst_n (rst_n), .pin_i (~cs_n),
      .rise_o (cs_fall), .fall_o (cs_rise)
   );

   hb_spi_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sck_edge (
      .clk (clk), .rst_n (rst_n), .pin_i (sck),
      .rise_o (sck_rise), .fall_o (sck_fall)
   );

   hb_spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sdi_sync (
      .clk (clk), .rst_n (rst_n), .pin_i (sdi), .sync_o (sdi_s)
   );

   // status word assembly
   always_comb begin
      status_w = '0;
      status_w[STS_TEMP_POS] = temp_warn;
      for (int k = 0; k < NUM_CH; k++) begin
         status_w[CTL_SW_BASE + 2*k]     = low_q[k];
         status_w[CTL_SW_BASE + 2*k + 1] = high_q[k];
      end
      for (int f = 0; f < NUM_FLT; f++) status_w[STS_FLT_BASE + f] = flt_q[f];
   end

   hb_spi_frame #(.WIDTH(FRAME_W)) i_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_fall_i  (cs_fall),
      .cs_rise_i  (cs_rise),
      .sck_rise_i (sck_rise),
      .sck_fall_i (sck_fall),
      .sdi_i      (sdi_s),
      .status_i   (status_w),
      .active_o   (active),
      .sdo_o      (sdo),
      .word_o     (rx_word),
      .frame_ok_o (frame_ok)
   );

   assign commit    = cs_rise & frame_ok;
   assign clr_flags = commit & rx_word[CTL_CLR_POS];

   assign flt_set[FLT_SHORT]  = ev_short;
   assign flt_set[FLT_OPEN]   = ev_open;
   assign flt_set[FLT_SUPPLY] = ev_supply;

   hb_fault_latch #(.N(NUM_FLT)) i_faults (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flt_set),
      .clr_i  (clr_flags),
      .flag_o (flt_q)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_q[k]  <= 1'b0;
               high_q[k] <= 1'b0;
            end else if (commit) begin
               low_q[k]  <= rx_word[CTL_SW_BASE + 2*k];
               high_q[k] <= rx_word[CTL_SW_BASE + 2*k + 1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ocs_q <= 1'b0;
      else if (commit) ocs_q <= rx_word[CTL_OCS_POS];
   end

   assign unused_bits = ^(rx_word & ~USED_MASK);

   assign low_en  = low_q;
   assign high_en = high_q;
   assign ocs_en  = ocs_q;
   assign sdo_oe  = active;

   AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable({low_q, high_q, ocs_q})); // R4
   AST_DROP_BAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && !frame_ok) |=> $stable({low_q, high_q, ocs_q})); // R5
   AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdo_oe); // R2
   AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> sdo_oe); // R2
   AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !sdo_oe |-> !sdo); // R2
endmodule

// File: tb/test_hb_drv_spi.sv
module test_hb_drv_spi;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic temp_warn = 1'b0, ev_short = 1'b0, ev_open = 1'b0, ev_supply = 1'b0;
   logic [2:0] low_en, high_en;
   logic ocs_en, sdo, sdo_oe;

   int n_run = 0;
   int n_fail = 0;
   logic oe_mid;
   logic [15:0] dout;
   logic [15:0] prev_sw;

   always #4 clk = ~clk;

   hb_drv_spi i_hb_drv_spi (
      .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sck (sck), .sdi (sdi),
      .temp_warn (temp_warn), .ev_short (ev_short), .ev_open (ev_open),
      .ev_supply (ev_supply), .low_en (low_en), .high_en (high_en),
      .ocs_en (ocs_en), .sdo (sdo), .sdo_oe (sdo_oe)
   );

   // {din, exp low, exp high, exp ocs}
   localparam logic [22:0] VEC [5] = '{
      {16'h0002, 3'b001, 3'b000, 1'b0},
      {16'h0054, 3'b000, 3'b111, 1'b0},
      {16'h202A, 3'b111, 3'b000, 1'b1},
      {16'hDF80, 3'b000, 3'b000, 1'b0},
      {16'hFFFE, 3'b111, 3'b111, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] din, input int nf, output logic [15:0] d);
      d = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nf; i++) begin
         sdi = din[i % 16];
         sck = 1'b1;
         repeat (H) @(negedge clk);
         if (i < 16) d[i] = sdo;
         oe_mid = sdo_oe;
         sck = 1'b0;
         repeat (H) @(negedge clk);
      end
   endtask

   task automatic release_cs();
      cs_n = 1'b1;
      repeat (H) @(negedge clk);
   endtask

   task automatic pulse_supply();
      @(negedge clk) ev_supply = 1'b1;
      @(negedge clk) ev_supply = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      chk("R1 low_en", 32'(low_en), 32'h0);
      chk("R1 high_en", 32'(high_en), 32'h0);
      chk("R1 ocs_en", 32'(ocs_en), 32'h0);
      chk("R1 sdo_oe", 32'(sdo_oe), 32'h0);

      // vector table: R3 R6 R7 R8
      prev_sw = '0;
      for (int j = 0; j < 5; j++) begin
         xfer(VEC[j][22:7], 16, dout);
         release_cs();
         chk("R7 R8 status word", 32'(dout), 32'(prev_sw & 16'h007E));
         chk("R3 R6 control outputs", 32'({low_en, high_en, ocs_en}), 32'(VEC[j][6:0]));
         prev_sw = VEC[j][22:7];
      end

      // R2 output enable
      chk("R2 oe during frame", 32'(oe_mid), 32'h1);
      chk("R2 oe after frame", 32'(sdo_oe), 32'h0);

      // R5 wrong lengths dropped (state is all on)
      xfer(16'h0000, 15, dout);
      release_cs();
      chk("R5 15 falls dropped", 32'({low_en, high_en, ocs_en}), 32'h7F);
      xfer(16'h0000, 17, dout);
      release_cs();
      chk("R5 17 falls dropped", 32'({low_en, high_en, ocs_en}), 32'h7F);

      // R10 R8 flags set and reported
      temp_warn = 1'b1;
      @(negedge clk) ev_short = 1'b1; ev_open = 1'b1;
      @(negedge clk) ev_short = 1'b0; ev_open = 1'b0;
      xfer(16'h0000, 16, dout);
      release_cs();
      chk("R8 R10 flags in status", 32'(dout), 32'h607F);

      // R9 supply event mid-frame not in this frame
      fork
         xfer(16'h0000, 16, dout);
         begin repeat (100) @(negedge clk); pulse_supply(); end
      join
      release_cs();
      chk("R9 snapshot excludes late event", 32'(dout), 32'h6001);

      // R10 sticky plus clear request
      xfer(16'h0001, 16, dout);
      release_cs();
      chk("R10 R9 flags still set", 32'(dout), 32'hE001);

      // R11 cleared, temp unaffected
      xfer(16'h0000, 16, dout);
      release_cs();
      chk("R11 flags cleared", 32'(dout), 32'h0001);

      // R4 commit latency and R12 set wins over clear
      xfer(16'h0003, 16, dout);
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
      @(negedge clk) ev_short = 1'b1;
      chk("R4 not yet committed", 32'(low_en), 32'h0);
      @(negedge clk) ev_short = 1'b0;
      chk("R4 committed on third edge", 32'(low_en), 32'h1);
      repeat (H) @(negedge clk);
      xfer(16'h0000, 16, dout);
      release_cs();
      chk("R12 strobe beats clear", 32'(dout), 32'h2003);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule